// File: doc/BRIEF.md
# Key-Protected Flash Command Controller

This block sits in front of a small on-chip flash array. It carries out three operations on that array: programming a single 32-bit word, erasing one page, and erasing the whole array. Software loads an address register and a data register through a simple register port. It then writes a command word to start the operation. The command word must carry a 16-bit unlock key in its upper half, or the block discards it. This guards the array against stray stores.

Each command bit also acts as the status of its own operation. The bit reads 1 while the operation runs and clears by itself when the operation ends. Programming behaves like real flash and can only move bits from 1 to 0. A request to turn a stored 0 back into 1 leaves that bit at 0 and raises an invalid-data event. Every completed operation raises a done event. Program and erase latency are separate parameters counted in clock cycles, and so are the array and page sizes. A fourth register slot reads the array word selected by the address register.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the address, data and command slots read 0, no operation is busy, no event is raised, and every array word reads 0xFFFFFFFF.
- R2: Register slot 0 holds a byte offset in bits 19:0 and reads 0 in bits 31:20. Slot 1 holds a 32-bit data word and reads it back unchanged.
- R3: A write to slot 2 (the command slot) is acted on only when bits 31:16 equal 0xA442. With any other key the write has no effect. Bits 31:3 of slot 2 always read 0, so the key never reads back.
- R4: The command bits are bit 0 for word program, bit 1 for page erase and bit 2 for mass erase. A keyed write with none of these bits set, or with more than one set, starts nothing.
- R5: After an accepted command, its bit reads 1 for exactly PROG_CYCLES cycles for a program, or ERASE_CYCLES cycles for an erase, starting in the cycle after the write. It then reads 0.
- R6: A command written while an operation is busy is ignored and leaves the running operation unchanged.
- R7: A word program stores the old word AND the data word at word index address[WIDX+1:2]. The address and data are captured in the cycle the command is accepted.
- R8: If a program requests a 1 on a bit that holds 0, evt_invalid pulses for one cycle together with that operation's done pulse.
- R9: A page erase sets every word of the PAGE_BYTES page that holds the address to 0xFFFFFFFF and leaves other pages untouched. A mass erase sets every word of the array to 0xFFFFFFFF. Erase ignores the data register.
- R10: evt_done pulses for one cycle in the first cycle after each operation finishes, which is the cycle its busy bit reads 0 again.
- R11: Slot 3 reads the array word selected by the address register. Writes to slot 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Slot select: 0 address, 1 data, 2 command, 3 array read |
| reg_wdata | input | 32 | Register write data |
| rd_data | output | 32 | Read data of the selected slot |
| evt_done | output | 1 | One-cycle pulse when an operation completes |
| evt_invalid | output | 1 | One-cycle pulse when a program asked to raise a 0 bit |

## Verification
The bench programs the same word twice. The first pass lowers some bits. The second pass asks for some of those bits back at 1, which shows whether the design overwrites the word instead of ANDing into it and whether it misses the invalid-data event. A second program that only clears further bits must not raise the event, so a design that flags every program as invalid is caught.

It sends commands with a wrong key, with no command bit set, with two bits set, and in the middle of a page erase. A design that is lax on any of these starts a program and changes a word that must stay put. It also checks a page erase against a word in the neighbouring page, which catches a wrong page mask that erases too much. Busy time is measured against each latency parameter, so a counter that is off by one cycle shows up.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int unsigned DW = 32;
   localparam logic [15:0] UNLOCK_KEY = 16'hA442;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CMD  = 2'd2,
      SEL_PEEK = 2'd3
   } slot_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PROG = 2'd1,
      OP_PAGE = 2'd2,
      OP_MASS = 2'd3
   } op_e;

   localparam int unsigned BIT_PROG = 0;
   localparam int unsigned BIT_PAGE = 1;
   localparam int unsigned BIT_MASS = 2;

endpackage

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              busy,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DW-1:0]     data_q,
   output logic              start,
   output op_e               start_op
);

   logic       cmd_wr;
   logic       key_ok;
   logic [2:0] req_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (reg_we) begin
         if (reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
         if (reg_sel == SEL_DATA) data_q <= reg_wdata;
      end
   end

   assign cmd_wr   = reg_we && (reg_sel == SEL_CMD);
   assign key_ok   = (reg_wdata[DW-1:DW-16] == UNLOCK_KEY);
   assign req_bits = reg_wdata[2:0];

   always_comb begin
      unique case (req_bits)
         3'b001:  start_op = OP_PROG;
         3'b010:  start_op = OP_PAGE;
         3'b100:  start_op = OP_MASS;
         default: start_op = OP_NONE;
      endcase
   end

   assign start = cmd_wr && key_ok && !busy && (start_op != OP_NONE);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W       = 20,
   parameter int unsigned PROG_CYCLES  = 4,
   parameter int unsigned ERASE_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  op_e               start_op,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DW-1:0]     data_in,
   output op_e               op_q,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DW-1:0]     op_data,
   output logic              busy,
   output logic [2:0]        busy_bits,
   output logic              fin
);

   localparam int unsigned MAX_LAT = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int unsigned CW      = $clog2(MAX_LAT + 1);
   localparam logic [CW-1:0] PLOAD = CW'(PROG_CYCLES - 1);
   localparam logic [CW-1:0] ELOAD = CW'(ERASE_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign busy = (op_q != OP_NONE);
   assign fin  = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         cnt_q   <= '0;
         op_addr <= '0;
         op_data <= '0;
      end else if (start) begin
         op_q    <= start_op;
         cnt_q   <= (start_op == OP_PROG) ? PLOAD : ELOAD;
         op_addr <= addr_in;
         op_data <= data_in;
      end else if (fin) begin
         op_q <= OP_NONE;
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      busy_bits           = '0;
      busy_bits[BIT_PROG] = (op_q == OP_PROG);
      busy_bits[BIT_PAGE] = (op_q == OP_PAGE);
      busy_bits[BIT_MASS] = (op_q == OP_MASS);
   end

endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned MEM_WORDS  = 512,
   parameter int unsigned PAGE_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fin,
   input  op_e               op,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DW-1:0]     op_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DW-1:0]     peek_data,
   output logic              bad_raise
);

   localparam int unsigned WIDX   = $clog2(MEM_WORDS);
   localparam int unsigned PWORDS = PAGE_BYTES / 4;
   localparam int unsigned PSHIFT = $clog2(PWORDS);

   logic [DW-1:0]   mem [MEM_WORDS];
   logic [WIDX-1:0] op_idx;
   logic [WIDX-1:0] peek_idx;
   logic [DW-1:0]   old_word;

   assign op_idx   = op_addr[WIDX+1:2];
   assign peek_idx = peek_addr[WIDX+1:2];
   assign old_word = mem[op_idx];

   assign bad_raise = fin && (op == OP_PROG) && (|(op_data & ~old_word));
   assign peek_data = mem[peek_idx];

   for (genvar g = 0; g < MEM_WORDS; g++) begin : g_word
      localparam logic [WIDX-1:0] MY_IDX = WIDX'(g);
      logic [DW-1:0] word_q;
      logic          same_page;

      assign same_page = ((op_idx >> PSHIFT) == (MY_IDX >> PSHIFT));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '1;
         end else if (fin) begin
            unique case (op)
               OP_PROG: if (op_idx == MY_IDX) word_q <= word_q & op_data;
               OP_PAGE: if (same_page) word_q <= '1;
               OP_MASS: word_q <= '1;
               default: word_q <= word_q;
            endcase
         end
      end

      assign mem[g] = word_q;
   end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W       = 20,
   parameter int unsigned MEM_WORDS    = 512,
   parameter int unsigned PAGE_BYTES   = 1024,
   parameter int unsigned PROG_CYCLES  = 4,
   parameter int unsigned ERASE_CYCLES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] rd_data,
   output logic        evt_done,
   output logic        evt_invalid
);

   localparam int unsigned WIDX = $clog2(MEM_WORDS);

   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_lat
      $error("latency parameters must be at least 1");
   end
   if ((1 << WIDX) != MEM_WORDS || WIDX + 2 > ADDR_W) begin : g_bad_mem
      $error("MEM_WORDS must be a power of two addressable by ADDR_W");
   end
   if (PAGE_BYTES < 4 || PAGE_BYTES > MEM_WORDS * 4 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two within the array");
   end
   if (ADDR_W > DW - 1) begin : g_bad_addr
      $error("ADDR_W too wide");
   end

   logic [ADDR_W-1:0] addr_q, op_addr;
   logic [DW-1:0]     data_q, op_data, peek_data;
   logic              start, busy, fin, bad_raise;
   logic [2:0]        busy_bits;
   op_e               start_op, op_q;

   flash_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .busy(busy), .addr_q(addr_q), .data_q(data_q),
      .start(start), .start_op(start_op)
   );

   flash_cmd_seq #(
      .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
      .addr_in(addr_q), .data_in(data_q), .op_q(op_q), .op_addr(op_addr),
      .op_data(op_data), .busy(busy), .busy_bits(busy_bits), .fin(fin)
   );

   flash_cmd_array #(
      .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS), .PAGE_BYTES(PAGE_BYTES)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .fin(fin), .op(op_q), .op_addr(op_addr),
      .op_data(op_data), .peek_addr(addr_q), .peek_data(peek_data),
      .bad_raise(bad_raise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_done    <= 1'b0;
         evt_invalid <= 1'b0;
      end else begin
         evt_done    <= fin;
         evt_invalid <= bad_raise;
      end
   end

   always_comb begin
      unique case (reg_sel)
         SEL_ADDR: rd_data = {{(DW-ADDR_W){1'b0}}, addr_q};
         SEL_DATA: rd_data = data_q;
         SEL_CMD:  rd_data = {29'b0, busy_bits};
         default:  rd_data = peek_data;
      endcase
   end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [1:0]  reg_sel,
   input logic [31:0] reg_wdata,
   input logic [31:0] rd_data,
   input logic [2:0]  busy_bits,
   input logic        evt_done,
   input logic        evt_invalid
);

   logic busy;
   assign busy = |busy_bits;

   assert_one_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy_bits));

   assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(busy_bits));

   assert_key_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 2'd2 && reg_wdata[31:16] != 16'hA442 && !busy) |=> !busy);

   assert_multi_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 2'd2 && $countones(reg_wdata[2:0]) != 1 && !busy) |=> !busy);

   assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |-> (!busy && $past(busy)));

   assert_invalid_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_invalid |-> evt_done);

   assert_addr_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd0) |-> (rd_data[31:20] == 12'h0));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
   .reg_wdata(reg_wdata), .rd_data(rd_data), .busy_bits(busy_bits),
   .evt_done(evt_done), .evt_invalid(evt_invalid)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;

   localparam int PROG_LAT  = 4;
   localparam int ERASE_LAT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rd_data;
   logic        evt_done, evt_invalid;

   int n_checks = 0;
   int n_fail   = 0;
   int done_cnt = 0;
   int inv_cnt  = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #2 clk = ~clk;

   flash_cmd_ctrl #(.PROG_CYCLES(PROG_LAT), .ERASE_CYCLES(ERASE_LAT)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .rd_data(rd_data), .evt_done(evt_done),
      .evt_invalid(evt_invalid)
   );

   always @(negedge clk) begin
      if (rst_n && evt_done) done_cnt++;
      if (rst_n && evt_invalid) inv_cnt++;
   end

   // monitor: pops expected items and compares with the read port
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (rd_data !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.exp);
            end
         end
      end
   end

   task automatic check_int(int act, int exp, string tag);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [1:0] sel, logic [31:0] exp, string tag);
      item_t it;
      reg_sel = sel;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic busy_len(output int n);
      n = 0;
      reg_sel = 2'd2;
      #1;
      while (rd_data[2:0] != 3'b000 && n < 1000) begin
         n++;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
   endtask

   task automatic cmd(logic [2:0] bits, int exp_lat, string tag);
      int n;
      wr(2'd2, {16'hA442, 13'h0, bits});
      busy_len(n);
      check_int(n, exp_lat, tag);
   endtask

   initial begin
      int d0, i0, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, 32'h0, "R1 address slot");
      rd(2'd1, 32'h0, "R1 data slot");
      rd(2'd2, 32'h0, "R1 command slot");
      rd(2'd3, 32'hFFFF_FFFF, "R1 array erased");
      check_int(done_cnt + inv_cnt, 0, "R1 no events");

      // R2 address masking, data readback
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, 32'h000F_FFFF, "R2 address upper bits zero");
      wr(2'd1, 32'h1357_9BDF);
      rd(2'd1, 32'h1357_9BDF, "R2 data readback");

      // R7 first program, R5 latency, R10 done
      wr(2'd0, 32'h0000_0010);
      wr(2'd1, 32'hA5A5_0F0F);
      d0 = done_cnt;
      cmd(3'b001, PROG_LAT, "R5 program busy cycles");
      check_int(done_cnt - d0, 1, "R10 done pulse after program");
      rd(2'd3, 32'hA5A5_0F0F, "R7 program result");

      // R8 raising a cleared bit
      wr(2'd1, 32'hFFFF_00FF);
      i0 = inv_cnt;
      cmd(3'b001, PROG_LAT, "R5 second program busy");
      check_int(inv_cnt - i0, 1, "R8 invalid raised");
      rd(2'd3, 32'hA5A5_000F, "R7 AND-only program");

      // R8 clearing only: no invalid event
      wr(2'd1, 32'h2525_000F);
      i0 = inv_cnt;
      cmd(3'b001, PROG_LAT, "R5 third program busy");
      check_int(inv_cnt - i0, 0, "R8 no invalid on pure clear");
      rd(2'd3, 32'h2525_000F, "R7 clear-only program");

      // R3 wrong key, key not read back
      wr(2'd1, 32'h0000_0000);
      d0 = done_cnt;
      wr(2'd2, 32'h1234_0001);
      rd(2'd2, 32'h0, "R3 wrong key starts nothing");
      repeat (PROG_LAT + 2) @(negedge clk);
      rd(2'd3, 32'h2525_000F, "R3 wrong key leaves word");
      check_int(done_cnt - d0, 0, "R3 no done after wrong key");

      // R4 no bits, two bits
      wr(2'd2, 32'hA442_0000);
      rd(2'd2, 32'h0, "R4 keyed write with no bit");
      wr(2'd2, 32'hA442_0003);
      rd(2'd2, 32'h0, "R4 two command bits ignored");
      repeat (ERASE_LAT + 2) @(negedge clk);
      rd(2'd3, 32'h2525_000F, "R4 word untouched");
      check_int(done_cnt - d0, 0, "R4 no done for rejected commands");

      // prepare word in page 1
      wr(2'd0, 32'h0000_0404);
      wr(2'd1, 32'h0000_0000);
      cmd(3'b001, PROG_LAT, "R5 page1 program busy");
      rd(2'd3, 32'h0, "R7 page1 word programmed");

      // R9 page erase of page 0, R6 command during busy
      wr(2'd0, 32'h0000_0010);
      wr(2'd1, 32'h0000_0000);
      wr(2'd2, 32'hA442_0002);
      wr(2'd2, 32'hA442_0001);
      rd(2'd2, 32'h0000_0002, "R6 erase still running, program rejected");
      busy_len(n);
      check_int(n, ERASE_LAT - 2, "R5 erase remaining busy");
      rd(2'd3, 32'hFFFF_FFFF, "R9 R6 page0 erased and no late program");
      wr(2'd0, 32'h0000_0404);
      rd(2'd3, 32'h0, "R9 other page untouched");
      wr(2'd0, 32'h0000_0008);
      rd(2'd3, 32'hFFFF_FFFF, "R9 page0 other word erased");

      // R9 mass erase, R5 erase latency
      wr(2'd0, 32'h0000_0404);
      d0 = done_cnt;
      cmd(3'b100, ERASE_LAT, "R5 mass erase busy cycles");
      check_int(done_cnt - d0, 1, "R10 done after mass erase");
      rd(2'd3, 32'hFFFF_FFFF, "R9 mass erase clears page1");

      // R11 slot 3 ignores writes
      wr(2'd3, 32'h0);
      rd(2'd3, 32'hFFFF_FFFF, "R11 write to array slot ignored");

      @(negedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule